// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block tracks the state of a single transmit buffer in a CAN controller. Software arms the buffer by raising a lock bit. It can ask for no retransmission after a failed attempt, and it can withdraw the frame by dropping the lock bit. A frame engine reports each transmission attempt through a simple event interface: attempt started, success, bus error, or arbitration lost. The block answers with a request to transmit and with ready, busy and buffer-empty status.

Whether an abort takes effect depends on how the attempt ended. After a success the buffer empties anyway, so any abort has nothing left to do. After a bus error, a no-retransmit request or a recorded abort empties the buffer. After lost arbitration the no-retransmit bit is ignored: ready stays set and only dropping the lock bit withdraws the frame, and it does so at once. No event reports a finished abort. Software learns of it only from the buffer-empty status.

The request toward the frame engine is a level held until accepted, in the manner of a valid/ready pair. `tx_req` stays high while a frame waits. The engine accepts it by pulsing `att_start`. A start pulse without a pending request is ignored. The engine may hold off as long as it likes: the request does not time out. All other pins are plain control and status levels.

Top module: `can_tx_abort_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, ready=0, busy=0, tx_req=0 and buf_empty=1.
- R2: A rising edge of `lock_bit` while the buffer is empty makes ready=1, busy=0 and buf_empty=0 after that clock edge. `tx_req` equals ready AND NOT busy AND `lock_bit`.
- R3: `att_start` sampled while `tx_req` is high sets busy and drops `tx_req` at the next edge. `att_start` without `tx_req` is ignored.
- R4: A success outcome while busy empties the buffer at the next edge, whatever `no_retx` and any recorded abort are.
- R5: A bus error while busy with `no_retx`=1 empties the buffer at the next edge, and no retry is requested.
- R6: A bus error while busy with `no_retx`=0, `lock_bit` high and no recorded abort clears busy, keeps ready set and raises `tx_req` again.
- R7: Lost arbitration while busy, with `lock_bit` high and no recorded abort, clears busy and keeps ready set, whatever `no_retx` is.
- R8: `lock_bit` low while ready=1 and busy=0 empties the buffer at the next edge.
- R9: `lock_bit` low while busy does not end the attempt: busy stays set until an outcome arrives. The abort is recorded, stays recorded if the lock returns high, and empties the buffer on any outcome.
- R10: While the buffer is empty, a lock fall, `no_retx` or outcome events change nothing. Outcome events while not busy are also ignored. A lock bit that stays high after the buffer empties does not re-arm it.
- R11: Outcomes arriving in the same cycle take priority success, then bus error, then lost arbitration.
- R12: busy implies ready, and buf_empty is always the inverse of ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the buffer |
| lock_bit | input | 1 | Software lock: rising edge arms, low level aborts |
| no_retx | input | 1 | Software no-retransmit request |
| att_start | input | 1 | Frame engine: attempt started (accepts tx_req) |
| att_ok | input | 1 | Frame engine: attempt succeeded |
| att_err | input | 1 | Frame engine: attempt ended in bus error |
| att_arb | input | 1 | Frame engine: attempt lost arbitration |
| ready | output | 1 | Frame pending in the buffer |
| busy | output | 1 | Attempt in progress |
| tx_req | output | 1 | Request to the frame engine to start an attempt |
| buf_empty | output | 1 | Buffer empty; the only sign that an abort finished |

## Verification
The assertions assume that the frame engine reports outcomes only for an attempt it has started. They also assume that a single-outcome property sees just one outcome pulse, so each such property masks the higher-priority outcomes in its trigger. The stimulus pulses every event for one cycle, aligned to the falling clock edge. It also drives deliberate outcome collisions and stray events outside an attempt, to exercise the priority and the ignore rules, and the properties are written to stay true under that stimulus.

// File: rtl/can_txab_pkg.sv
`timescale 1ns/1ps
package can_txab_pkg;
  typedef enum logic [1:0] {
    BUF_EMPTY   = 2'd0,
    BUF_PENDING = 2'd1,
    BUF_ACTIVE  = 2'd2
  } buf_state_e;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_OK   = 2'd1,
    OUT_ERR  = 2'd2,
    OUT_ARB  = 2'd3
  } outcome_e;
endpackage

// File: rtl/can_txab_outcome.sv
`timescale 1ns/1ps
module can_txab_outcome
  import can_txab_pkg::*;
(
  input  logic     in_attempt,
  input  logic     att_ok,
  input  logic     att_err,
  input  logic     att_arb,
  output outcome_e outcome
);
  // Fixed priority: success over bus error over lost arbitration (R11)
  always_comb begin
    outcome = OUT_NONE;
    if (in_attempt) begin
      if (att_ok)       outcome = OUT_OK;
      else if (att_err) outcome = OUT_ERR;
      else if (att_arb) outcome = OUT_ARB;
    end
  end
endmodule

// File: rtl/can_txab_abort_latch.sv
`timescale 1ns/1ps
module can_txab_abort_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic held_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     held_o <= 1'b0;
    else if (clr_i) held_o <= 1'b0;
    else if (set_i) held_o <= 1'b1;
  end

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !held_o);
endmodule

// File: rtl/can_tx_abort_ctrl.sv
`timescale 1ns/1ps
module can_tx_abort_ctrl
  import can_txab_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_bit,
  input  logic no_retx,
  input  logic att_start,
  input  logic att_ok,
  input  logic att_err,
  input  logic att_arb,
  output logic ready,
  output logic busy,
  output logic tx_req,
  output logic buf_empty
);
  buf_state_e state_q, state_d;
  outcome_e   outcome;
  logic       lock_q;
  logic       arm;
  logic       abort_held;
  logic       abort_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_bit;
  end

  assign arm = lock_bit & ~lock_q;

  can_txab_outcome u_outcome (
    .in_attempt (state_q == BUF_ACTIVE),
    .att_ok     (att_ok),
    .att_err    (att_err),
    .att_arb    (att_arb),
    .outcome    (outcome)
  );

  can_txab_abort_latch u_abort (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ((state_q == BUF_ACTIVE) & ~lock_bit),
    .clr_i  (state_q != BUF_ACTIVE),
    .held_o (abort_held)
  );

  assign abort_hit = abort_held | ~lock_bit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUF_EMPTY:   if (arm) state_d = BUF_PENDING;
      BUF_PENDING: begin
        if (!lock_bit)      state_d = BUF_EMPTY;
        else if (att_start) state_d = BUF_ACTIVE;
      end
      BUF_ACTIVE: begin
        unique case (outcome)
          OUT_OK:   state_d = BUF_EMPTY;
          OUT_ERR:  state_d = (no_retx | abort_hit) ? BUF_EMPTY : BUF_PENDING;
          OUT_ARB:  state_d = abort_hit ? BUF_EMPTY : BUF_PENDING;
          default:  state_d = BUF_ACTIVE;
        endcase
      end
      default:     state_d = BUF_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= BUF_EMPTY;
    else        state_q <= state_d;
  end

  assign ready     = (state_q != BUF_EMPTY);
  assign busy      = (state_q == BUF_ACTIVE);
  assign buf_empty = (state_q == BUF_EMPTY);
  assign tx_req    = (state_q == BUF_PENDING) & lock_bit;

  assert_busy_needs_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ready);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && att_start) |=> (busy && !tx_req));
  assert_success_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && att_ok) |=> buf_empty);
  assert_noretx_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && att_err && !att_ok && no_retx) |=> buf_empty);
  assert_arb_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && att_arb && !att_ok && !att_err && lock_bit && !abort_held)
      |=> (ready && !busy));
  assert_lock_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !busy && !lock_bit) |=> buf_empty);
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !att_ok && !att_err && !att_arb) |=> busy);
  assert_empty_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_empty && !(lock_bit && !lock_q)) |=> buf_empty);
endmodule

// File: tb/test_can_tx_abort_ctrl.sv
`timescale 1ns/1ps
module test_can_tx_abort_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock_bit = 1'b0, no_retx = 1'b0;
  logic att_start = 1'b0, att_ok = 1'b0, att_err = 1'b0, att_arb = 1'b0;
  logic ready, busy, tx_req, buf_empty;

  int total = 0;
  int bad = 0;

  // expected vector {ready, busy, tx_req, buf_empty}
  localparam logic [3:0] XE = 4'b0001;
  localparam logic [3:0] XP = 4'b1010;
  localparam logic [3:0] XA = 4'b1100;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  can_tx_abort_ctrl i_can_tx_abort_ctrl (
    .clk(clk), .rst_n(rst_n), .lock_bit(lock_bit), .no_retx(no_retx),
    .att_start(att_start), .att_ok(att_ok), .att_err(att_err), .att_arb(att_arb),
    .ready(ready), .busy(busy), .tx_req(tx_req), .buf_empty(buf_empty)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    total++;
    if ({ready, busy, tx_req, buf_empty} !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, {ready, busy, tx_req, buf_empty}, exp);
    end
  endtask

  // driver: apply one cycle of inputs, push outcome expected after the edge
  task automatic step(input logic lk, input logic nr, input logic st,
                      input logic ok, input logic er, input logic ar,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    lock_bit = lk; no_retx = nr; att_start = st;
    att_ok = ok; att_err = er; att_arb = ar;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compare 5 ns after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e, t);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(XE, "R1 in reset");
    rst_n = 1'b1;
    step(0,0,0,0,0,0, XE, "R1 after reset");
    step(1,0,0,0,0,0, XP, "R2 arm on lock rise");
    step(1,0,0,0,0,0, XP, "R2 request held");
    step(1,0,1,0,0,0, XA, "R3 start accepted");
    step(1,0,0,0,0,0, XA, "R9 busy holds");
    step(1,0,0,1,0,0, XE, "R4 success empties");
    step(1,0,0,0,0,0, XE, "R10 held lock no rearm");
    step(0,1,0,1,1,1, XE, "R10 empty ignores abort and events");
    step(0,0,1,0,0,0, XE, "R3 start without request ignored");
    step(1,0,0,0,0,0, XP, "R2 rearm");
    step(1,0,0,1,0,0, XP, "R10 outcome while pending ignored");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(1,0,0,0,1,0, XP, "R6 error retries");
    step(1,0,1,0,0,0, XA, "R3 restart");
    step(1,1,0,0,0,1, XP, "R7 arb lost ignores no_retx");
    step(0,1,0,0,0,0, XE, "R8 lock clear aborts at once");
    step(1,0,0,0,0,0, XP, "R2 arm");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(1,1,0,0,0,0, XA, "R5 no_retx set while busy");
    step(1,1,0,0,1,0, XE, "R5 error with no_retx empties");
    step(0,0,0,0,0,0, XE, "R10 drop lock");
    step(1,0,0,0,0,0, XP, "R2 arm");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(0,0,0,0,0,0, XA, "R9 lock clear while busy keeps attempt");
    step(0,0,0,0,0,1, XE, "R9 abort applied on arb lost");
    step(1,0,0,0,0,0, XP, "R2 arm");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(0,0,0,0,0,0, XA, "R9 abort recorded");
    step(1,0,0,0,0,0, XA, "R9 abort sticky with lock back");
    step(1,0,0,0,0,1, XE, "R9 recorded abort applied on arb lost");
    step(0,0,0,0,0,0, XE, "R10 drop lock");
    step(1,0,0,0,0,0, XP, "R2 arm");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(1,0,0,0,1,1, XP, "R11 error over arb, retry");
    step(1,0,1,0,0,0, XA, "R3 restart");
    step(1,1,0,0,1,1, XE, "R11 error over arb with no_retx");
    step(0,0,0,0,0,0, XE, "R10 drop lock");
    step(1,0,0,0,0,0, XP, "R2 arm");
    step(1,0,1,0,0,0, XA, "R3 start");
    step(1,0,0,1,0,1, XE, "R11 success over arb");
    step(0,0,0,0,0,0, XE, "R12 empty consistent");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule